// File: doc/BRIEF.md
# Polarity-Free OOK Envelope Receiver

This block turns a sampled on-off keyed bus signal back into a data bit. Each clock brings one signed sample of the differential amplitude, already band-limited upstream. The block folds the sample to its absolute value, so the polarity of the bus wires makes no difference. It then holds the largest magnitude seen over a window as long as one carrier period. The window length comes from a small carrier-select word.

Each window ends with one envelope value. That value is classed against two magnitude thresholds: above the upper one means a carrier is present, below the lower one means the line is quiet, and anything between falls in a hysteresis band. A class has to repeat in consecutive windows before the data bit moves. A present carrier drives the bit low. A quiet line drives it high, which also covers a bus that is idle, open or shorted. A band class leaves the bit where it was.

While the node transmits, the output enable is dropped and the detector is cleared to its quiet state. Each return to receive therefore starts from a high bit.

Top module: `ook_envelope_rx`

## Requirements
- R1: While `rst` is high, `rx_data_o` is 1 and `rx_oe_o` is 0.
- R2: Only the magnitude of `sample_i` (two's complement) is used, so negating every sample gives the same `rx_data_o`. The most negative code counts as the largest positive magnitude.
- R3: When a window's peak magnitude is at least `TH_CARRIER` (default 1200) in `CONFIRM_WIN` (default 2) consecutive windows, `rx_data_o` becomes 0.
- R4: When a window's peak magnitude is below `TH_QUIET` (default 400) in `CONFIRM_WIN` consecutive windows, `rx_data_o` becomes 1.
- R5: A window whose peak lies in the band from `TH_QUIET` up to `TH_CARRIER` minus one leaves `rx_data_o` unchanged, whether it was 0 or 1.
- R6: A carrier or quiet class seen in a single window, with no repeat in the next window, does not change `rx_data_o`. An isolated one-sample spike is one such case.
- R7: A line whose samples stay at zero differential keeps `rx_data_o` at 1.
- R8: One clock edge after `tx_mode_i` is 1, `rx_oe_o` is 0 and `rx_data_o` is 1. The detector is cleared while `tx_mode_i` is 1. After the return to receive, `rx_data_o` stays 1 until a carrier has been confirmed again.
- R9: A window lasts `PER_MIN + fsel_i * PER_STEP` clocks (defaults 8 and 4). A pulse train of that period reads as carrier. A train of twice that period changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | SAMPLE_W | Signed differential amplitude sample, one per clock |
| tx_mode_i | input | 1 | 1 = node transmits (receiver off), 0 = receive |
| fsel_i | input | FSEL_W | Carrier-select word that sets the window length |
| rx_data_o | output | 1 | Recovered data bit, 0 while a carrier is present |
| rx_oe_o | output | 1 | Output enable for the data bit, 0 in transmit mode |

## Verification
The checker holds these rules on every cycle: the output enable follows the mode input, the data bit stays high while disabled, and a band-class window never moves the decision. It also checks that each fall of the decision comes from a window at or above the carrier threshold, and each rise from a quiet window or from transmit mode. What only the bench's scenarios can show is end-to-end. That covers polarity swap, saturation of the most negative code, the two-window confirmation against single spikes, the window length set by the select word, and the restart to high after a transmit period. All of these are checked against a bench model over directed and random segments.

// File: rtl/ook_rx_pkg.sv
package ook_rx_pkg;

  // class of one window's envelope against the two thresholds
  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_QUIET = 2'd1,
    CLS_BAND  = 2'd2,
    CLS_CARR  = 2'd3
  } env_class_e;

endpackage

// File: rtl/ook_win_timer.sv
// Window timer: one pulse per carrier period, length set by the select word.
module ook_win_timer #(
  parameter int FSEL_W   = 2,
  parameter int PER_MIN  = 8,
  parameter int PER_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [FSEL_W-1:0] fsel,
  output logic              win_end
);

  localparam int PER_MAX = PER_MIN + ((1 << FSEL_W) - 1) * PER_STEP;
  localparam int CNT_W   = (PER_MAX > 1) ? $clog2(PER_MAX) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;
  int               len_i;

  always_comb begin
    len_i    = PER_MIN + int'(fsel) * PER_STEP;
    last_idx = CNT_W'(len_i - 1);
  end

  // >= so that a select change mid-window never overruns the counter
  assign win_end = (cnt_q >= last_idx) && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (win_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/ook_peak_hold.sv
// Folds each sample to its magnitude and keeps the window maximum.
module ook_peak_hold #(
  parameter int SAMPLE_W = 12,
  parameter bit IN_REG   = 1'b1,
  localparam int MAG_W   = SAMPLE_W - 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic                       win_end,
  output logic [MAG_W-1:0]           env_q,
  output logic                       env_valid
);

  localparam logic [MAG_W-1:0]    MAG_MAX = {MAG_W{1'b1}};
  localparam logic [SAMPLE_W-1:0] NEG_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] neg_s;
  logic [MAG_W-1:0]    mag_now;
  logic [MAG_W-1:0]    mag_use;
  logic [MAG_W-1:0]    acc_q;
  logic [MAG_W-1:0]    acc_max;

  // absolute value with saturation of the most negative code
  always_comb begin
    neg_s = ~sample + SAMPLE_W'(1);
    if (!sample[SAMPLE_W-1]) begin
      mag_now = sample[MAG_W-1:0];
    end else if (sample == NEG_MIN) begin
      mag_now = MAG_MAX;
    end else begin
      mag_now = neg_s[MAG_W-1:0];
    end
  end

  generate
    if (IN_REG) begin : g_in_reg
      logic [MAG_W-1:0] mag_q;
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          mag_q <= '0;
        end else begin
          mag_q <= mag_now;
        end
      end
      assign mag_use = mag_q;
    end else begin : g_in_comb
      assign mag_use = mag_now;
    end
  endgenerate

  assign acc_max = (mag_use > acc_q) ? mag_use : acc_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q     <= '0;
      env_q     <= '0;
      env_valid <= 1'b0;
    end else if (win_end) begin
      env_q     <= acc_max;
      env_valid <= 1'b1;
      acc_q     <= '0;
    end else begin
      acc_q     <= acc_max;
      env_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/ook_hyst_decide.sv
// Two-threshold decision with confirmation over consecutive windows.
module ook_hyst_decide
  import ook_rx_pkg::*;
#(
  parameter int MAG_W       = 11,
  parameter int TH_CARRIER  = 1200,
  parameter int TH_QUIET    = 400,
  parameter int CONFIRM_WIN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [MAG_W-1:0] env_q,
  input  logic             env_valid,
  output logic             dec_r
);

  localparam logic [MAG_W-1:0] TH_C  = MAG_W'(TH_CARRIER);
  localparam logic [MAG_W-1:0] TH_Q  = MAG_W'(TH_QUIET);
  localparam int               STK_W = $clog2(CONFIRM_WIN + 1);

  env_class_e cls_now;

  always_comb begin
    if (env_q >= TH_C) begin
      cls_now = CLS_CARR;
    end else if (env_q < TH_Q) begin
      cls_now = CLS_QUIET;
    end else begin
      cls_now = CLS_BAND;
    end
  end

  generate
    if (CONFIRM_WIN <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          dec_r <= 1'b1;
        end else if (env_valid) begin
          if (cls_now == CLS_CARR) begin
            dec_r <= 1'b0;
          end else if (cls_now == CLS_QUIET) begin
            dec_r <= 1'b1;
          end
        end
      end
    end else begin : g_streak
      env_class_e       prev_q;
      logic [STK_W-1:0] streak_q;
      logic [STK_W-1:0] streak_nx;
      logic             confirmed;

      always_comb begin
        if (cls_now != prev_q) begin
          streak_nx = STK_W'(1);
        end else if (streak_q >= STK_W'(CONFIRM_WIN)) begin
          streak_nx = streak_q;
        end else begin
          streak_nx = streak_q + STK_W'(1);
        end
        confirmed = (streak_nx >= STK_W'(CONFIRM_WIN));
      end

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          prev_q   <= CLS_NONE;
          streak_q <= '0;
          dec_r    <= 1'b1;
        end else if (env_valid) begin
          prev_q   <= cls_now;
          streak_q <= streak_nx;
          if (confirmed && cls_now == CLS_CARR) begin
            dec_r <= 1'b0;
          end else if (confirmed && cls_now == CLS_QUIET) begin
            dec_r <= 1'b1;
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ook_envelope_rx.sv
// Top: envelope receiver with failsafe and output gating.
module ook_envelope_rx #(
  parameter int SAMPLE_W    = 12,
  parameter int FSEL_W      = 2,
  parameter int PER_MIN     = 8,
  parameter int PER_STEP    = 4,
  parameter int TH_CARRIER  = 1200,
  parameter int TH_QUIET    = 400,
  parameter int CONFIRM_WIN = 2,
  parameter bit IN_REG      = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       tx_mode_i,
  input  logic [FSEL_W-1:0]          fsel_i,
  output logic                       rx_data_o,
  output logic                       rx_oe_o
);

  localparam int MAG_W = SAMPLE_W - 1;

  logic             win_end;
  logic [MAG_W-1:0] env_q;
  logic             env_valid;
  logic             dec_r;

  ook_win_timer #(
    .FSEL_W  (FSEL_W),
    .PER_MIN (PER_MIN),
    .PER_STEP(PER_STEP)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (tx_mode_i),
    .fsel   (fsel_i),
    .win_end(win_end)
  );

  ook_peak_hold #(
    .SAMPLE_W(SAMPLE_W),
    .IN_REG  (IN_REG)
  ) u_peak (
    .clk      (clk),
    .rst      (rst),
    .clr      (tx_mode_i),
    .sample   (sample_i),
    .win_end  (win_end),
    .env_q    (env_q),
    .env_valid(env_valid)
  );

  ook_hyst_decide #(
    .MAG_W      (MAG_W),
    .TH_CARRIER (TH_CARRIER),
    .TH_QUIET   (TH_QUIET),
    .CONFIRM_WIN(CONFIRM_WIN)
  ) u_decide (
    .clk      (clk),
    .rst      (rst),
    .clr      (tx_mode_i),
    .env_q    (env_q),
    .env_valid(env_valid),
    .dec_r    (dec_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data_o <= 1'b1;
      rx_oe_o   <= 1'b0;
    end else begin
      rx_oe_o   <= !tx_mode_i;
      rx_data_o <= tx_mode_i ? 1'b1 : dec_r;
    end
  end

endmodule

// File: rtl/ook_rx_chk.sv
module ook_rx_chk #(
  parameter int MAG_W      = 11,
  parameter int TH_CARRIER = 1200,
  parameter int TH_QUIET   = 400
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_mode_i,
  input logic             rx_data_o,
  input logic             rx_oe_o,
  input logic             env_valid,
  input logic [MAG_W-1:0] env_q,
  input logic             dec_r
);

  localparam logic [MAG_W-1:0] TH_C = MAG_W'(TH_CARRIER);
  localparam logic [MAG_W-1:0] TH_Q = MAG_W'(TH_QUIET);

  AST_OE_OFF_IN_TX: assert property (@(posedge clk) disable iff (rst)
    tx_mode_i |=> !rx_oe_o);  // R8

  AST_OE_ON_IN_RX: assert property (@(posedge clk) disable iff (rst)
    !tx_mode_i |=> rx_oe_o);  // R8

  AST_HIGH_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !rx_oe_o |-> rx_data_o);  // R8

  AST_FALL_ON_CARRIER: assert property (@(posedge clk) disable iff (rst)
    $fell(dec_r) |-> ($past(env_valid) && ($past(env_q) >= TH_C)));  // R3

  AST_RISE_ON_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(dec_r) |-> ($past(tx_mode_i) || ($past(env_valid) && ($past(env_q) < TH_Q))));  // R4

  AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (env_valid && !tx_mode_i && env_q >= TH_Q && env_q < TH_C) |=> $stable(dec_r));  // R5

endmodule

bind ook_envelope_rx ook_rx_chk #(
  .MAG_W     (SAMPLE_W - 1),
  .TH_CARRIER(TH_CARRIER),
  .TH_QUIET  (TH_QUIET)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_mode_i(tx_mode_i),
  .rx_data_o(rx_data_o),
  .rx_oe_o  (rx_oe_o),
  .env_valid(env_valid),
  .env_q    (env_q),
  .dec_r    (dec_r)
);

// File: tb/test_ook_envelope_rx.sv
`timescale 1ns/1ps
module test_ook_envelope_rx;

  localparam int SAMPLE_W = 12;
  localparam int FSEL_W   = 2;
  localparam int PER_MIN  = 8;
  localparam int PER_STEP = 4;
  localparam int TH_C     = 1200;
  localparam int TH_Q     = 400;
  localparam int WD_LIMIT = 150000;

  logic                       clk = 1'b0;
  logic                       rst = 1'b1;
  logic signed [SAMPLE_W-1:0] sample_i = '0;
  logic                       tx_mode_i = 1'b0;
  logic [FSEL_W-1:0]          fsel_i = '0;
  logic                       rx_data_o;
  logic                       rx_oe_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic model_r;

  always #2.5 clk = ~clk;

  ook_envelope_rx i_ook_envelope_rx (
    .clk      (clk),
    .rst      (rst),
    .sample_i (sample_i),
    .tx_mode_i(tx_mode_i),
    .fsel_i   (fsel_i),
    .rx_data_o(rx_data_o),
    .rx_oe_o  (rx_oe_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WD_LIMIT) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual still running, expected done by %0d cycles", WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int win_len(input int f);
    return PER_MIN + f * PER_STEP;
  endfunction

  task automatic check(input logic got, input logic exp, input string tag);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(input int v);
    @(negedge clk);
    sample_i = SAMPLE_W'(v);
  endtask

  // carrier of period per: one peak each polarity, smaller values between
  task automatic run_carrier(input int amp, input bit neg, input int per, input int n);
    for (int i = 0; i < n; i++) begin
      int p = i % per;
      int v;
      if (p == 0) v = amp;
      else if (p == per / 2) v = -amp;
      else if (p < per / 2) v = amp / 3;
      else v = -(amp / 3);
      drive(neg ? -v : v);
    end
  endtask

  // one pulse every per clocks, zero in between; checks the output each cycle
  task automatic run_sparse(input int amp, input int per, input int n,
                            input bit watch, input logic exp, input string tag);
    bit bad = 1'b0;
    logic seen = exp;
    for (int i = 0; i < n; i++) begin
      drive(((i % per) == 0) ? amp : 0);
      if (watch && rx_data_o !== exp) begin
        bad = 1'b1;
        seen = rx_data_o;
      end
    end
    if (watch) check(bad ? seen : exp, exp, tag);
  endtask

  task automatic run_const(input int v, input int n, input bit watch,
                           input logic exp, input string tag);
    bit bad = 1'b0;
    logic seen = exp;
    for (int i = 0; i < n; i++) begin
      drive(v);
      if (watch && rx_data_o !== exp) begin
        bad = 1'b1;
        seen = rx_data_o;
      end
    end
    if (watch) check(bad ? seen : exp, exp, tag);
  endtask

  initial begin
    int len;
    void'($urandom(32'd2024));
    // reset
    repeat (4) @(negedge clk);
    check(rx_data_o, 1'b1, "R1 data in reset");
    check(rx_oe_o, 1'b0, "R1 oe in reset");
    rst = 1'b0;
    @(negedge clk);
    check(rx_oe_o, 1'b1, "R8 oe in receive");

    len = win_len(0);
    run_const(0, 6 * len, 1'b1, 1'b1, "R7 zero line stays high");

    run_carrier(1500, 1'b0, len, 8 * len);
    check(rx_data_o, 1'b0, "R3 carrier gives low");
    run_carrier(1500, 1'b1, len, 8 * len);
    check(rx_data_o, 1'b0, "R2 swapped carrier stays low");
    run_const(0, 8 * len, 1'b0, 1'b0, "");
    check(rx_data_o, 1'b1, "R7 idle after carrier goes high");
    run_carrier(1500, 1'b1, len, 8 * len);
    check(rx_data_o, 1'b0, "R2 swapped carrier from high");
    run_carrier(300, 1'b0, len, 8 * len);
    check(rx_data_o, 1'b1, "R4 weak signal gives high");

    // hysteresis band from both sides, and threshold edges
    run_carrier(800, 1'b0, len, 8 * len);
    check(rx_data_o, 1'b1, "R5 band holds high");
    run_carrier(TH_C, 1'b0, len, 8 * len);
    check(rx_data_o, 1'b0, "R3 exact carrier threshold");
    run_carrier(800, 1'b1, len, 8 * len);
    check(rx_data_o, 1'b0, "R5 band holds low");
    run_carrier(TH_Q, 1'b0, len, 8 * len);
    check(rx_data_o, 1'b0, "R5 exact quiet threshold is band");
    run_carrier(TH_Q - 1, 1'b1, len, 8 * len);
    check(rx_data_o, 1'b1, "R4 just below quiet threshold");

    // most negative code saturates to a large magnitude
    run_const(-2048, 6 * len, 1'b0, 1'b0, "");
    check(rx_data_o, 1'b0, "R2 most negative code reads carrier");
    run_const(0, 6 * len, 1'b0, 1'b0, "");

    // isolated spike must not move the output
    run_const(2000, 1, 1'b0, 1'b0, "");
    run_const(0, 6 * len, 1'b1, 1'b1, "R6 single spike ignored");

    // window length from the select word
    fsel_i = 2'd2;
    len = win_len(2);
    run_const(0, 4 * len, 1'b0, 1'b0, "");
    run_sparse(1500, 2 * len, 10 * len, 1'b1, 1'b1, "R9 half-rate pulses hold high");
    run_sparse(1500, len, 8 * len, 1'b0, 1'b0, "");
    check(rx_data_o, 1'b0, "R9 one pulse per window gives low");
    fsel_i = 2'd3;
    len = win_len(3);
    run_const(0, 6 * len, 1'b0, 1'b0, "");
    run_sparse(1500, len, 8 * len, 1'b0, 1'b0, "");
    check(rx_data_o, 1'b0, "R9 longest window pulses give low");
    fsel_i = 2'd0;
    len = win_len(0);
    run_sparse(1500, 2 * len, 10 * len, 1'b1, 1'b0, "R6 alternating windows hold low");

    // transmit mode
    run_carrier(1500, 1'b0, len, 6 * len);
    check(rx_data_o, 1'b0, "R3 carrier before transmit");
    @(negedge clk);
    tx_mode_i = 1'b1;
    @(negedge clk);
    check(rx_oe_o, 1'b0, "R8 oe off in transmit");
    check(rx_data_o, 1'b1, "R8 data high in transmit");
    run_carrier(1500, 1'b0, len, 4 * len);
    check(rx_oe_o, 1'b0, "R8 oe stays off");
    tx_mode_i = 1'b0;
    @(negedge clk);
    check(rx_oe_o, 1'b1, "R8 oe back on");
    run_carrier(1500, 1'b0, len, len);
    check(rx_data_o, 1'b1, "R8 restart reads high");
    run_carrier(1500, 1'b0, len, 6 * len);
    check(rx_data_o, 1'b0, "R8 carrier confirmed after restart");

    // random segments against the bench model
    model_r = 1'b0;
    for (int s = 0; s < 40; s++) begin
      int f   = int'($urandom_range(3, 0));
      int cls = int'($urandom_range(2, 0));
      bit neg = 1'($urandom_range(1, 0));
      int amp;
      if (cls == 0) amp = int'($urandom_range(TH_Q - 1, 0));
      else if (cls == 1) amp = int'($urandom_range(TH_C - 1, TH_Q));
      else amp = int'($urandom_range(2047, TH_C));
      fsel_i = FSEL_W'(f);
      len = win_len(f);
      run_carrier(amp, neg, len, 8 * len);
      if (cls == 0) model_r = 1'b1;
      else if (cls == 2) model_r = 1'b0;
      check(rx_data_o, model_r,
            (cls == 0) ? "R4 random quiet" : (cls == 1) ? "R5 random band" : "R3 random carrier");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule